// File: doc/BRIEF.md
# Grouped External Interrupt Router

This block turns pad activity into interrupt flags. It has sixteen edge-triggered lines and four level-triggered wake-up lines. Edge line n may watch one pad. The pad's port can be any port, but its pin number must fall in the same group of four as n, so lines 8..11 can only watch pins 8..11. Each line has its own rising-edge and falling-edge enables.

The wake-up lines watch dedicated wake pads. Each has a programmable active level and an enable. Edge and wake-up lines record into one shared pending-flag register, whose bits are tied to an enable register. Software sets and clears both registers with write-one strobes. The block drives a combined interrupt, plus two outputs split by even and odd flag index. It also reports which enabled wake-up lines have fired.

Each edge line runs a two-state controller:
- **LN_SETTLE**: edge detection is masked.
- **LN_ARMED**: edges are detected.

The transitions are:
- **reconfigure**: any write to the line's configuration moves it to LN_SETTLE, from either state.
- **settle-done**: from LN_SETTLE, the next cycle moves the line to LN_ARMED.
- **hold**: LN_ARMED stays in LN_ARMED.

Reset enters LN_SETTLE.

Top module: `eir_router`

## Requirements
- R1: After reset, all flags, enables, wake-up enables, polarities and line configurations are zero, and every interrupt output is low.
- R2: Line n watches pad bit `port*16 + 4*(n/4) + ofs`. Here `port` is the programmed port (0..3) and `ofs` is the programmed 2-bit offset. Pads outside that group never affect line n.
- R3: A rising edge of the watched pad sets flag bit n when rising is enabled. A falling edge sets it when falling is enabled. The flag is visible three clock edges after the pad changes (two synchroniser stages plus the flag register).
- R4: A configuration write to line n clears flag bit n and leaves enable bit n unchanged. The line enters LN_SETTLE for one cycle, so the change of watched pad cannot raise a flag.
- R5: A flag-set strobe ORs the write data into the flags, and a flag-clear strobe clears the flag bits where the data is one. Bits written as zero are unchanged.
- R6: The enable register has its own set and clear strobes with the same write-one meaning. When both hit one bit in a cycle, the bit ends up set.
- R7: A hardware set of a flag wins over a software clear of the same bit in the same cycle.
- R8: `active` equals flags AND enables, and `irq_any` is high exactly when `active` is nonzero.
- R9: `irq_even` is the OR of the even-indexed `active` bits, and `irq_odd` is the OR of the odd-indexed ones.
- R10: Wake-up line k owns flag bit 16+k. While it is enabled and its synchronised pad equals its polarity bit (1 = active-high, 0 = active-low), it sets the flag on every clock edge. The flag appears three edges after the pad reaches the active level.
- R11: `wake_cause` equals flag bits 19..16 ANDed with the wake-up enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 64 | Pad levels, bit = port*16 + pin |
| wake_pad | input | 4 | Dedicated wake-up pad levels |
| cfg_we | input | 1 | Line configuration write strobe |
| cfg_line | input | 4 | Line being configured |
| cfg_port | input | 2 | Source port for the line |
| cfg_ofs | input | 2 | Pin offset within the line's group |
| cfg_rise | input | 1 | Rising-edge enable |
| cfg_fall | input | 1 | Falling-edge enable |
| wake_cfg_we | input | 1 | Wake-up enable and polarity write strobe |
| wake_en_wdata | input | 4 | Wake-up enable mask |
| wake_pol_wdata | input | 4 | Wake-up polarity, 1 = active-high |
| flag_set_we | input | 1 | Flag set strobe |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_wdata | input | 20 | Flag write-one data |
| en_set_we | input | 1 | Enable set strobe |
| en_clr_we | input | 1 | Enable clear strobe |
| en_wdata | input | 20 | Enable write-one data |
| flags | output | 20 | Pending flags |
| enables | output | 20 | Interrupt enables |
| active | output | 20 | Flags AND enables |
| irq_any | output | 1 | Any active flag |
| irq_even | output | 1 | Any even-indexed active flag |
| irq_odd | output | 1 | Any odd-indexed active flag |
| wake_cause | output | 4 | Enabled wake-up flags |

## Verification
The assertions assume the following about the inputs:
- Every write strobe is a registered single-cycle pulse.
- `cfg_port` stays below the port count.
- Pad inputs may change at any time, because they pass through synchronisers before any checked logic.

The stimulus drives all strobes and pads only on the falling clock edge. It draws ports from 0..3 only, even in the randomised phase, and there it freely mixes simultaneous set, clear, configuration and hardware events on the same bits.

// File: rtl/eir_pkg.sv
package eir_pkg;
    // lines per group; the pin group of a line is line / GRP
    localparam int GRP = 4;

    typedef enum logic {
        LN_SETTLE = 1'b0,
        LN_ARMED  = 1'b1
    } ln_state_e;
endpackage

// File: rtl/eir_sync.sv
module eir_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/eir_line.sv
module eir_line
    import eir_pkg::*;
#(
    parameter int LINE  = 0,
    parameter int PORTS = 4,
    parameter int PINS  = 16,
    localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int NP    = PORTS * PINS,
    localparam int IW    = $clog2(NP),
    localparam int GBASE = (LINE / GRP) * GRP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pads_s,
    input  logic          cfg_wr,
    input  logic [PW-1:0] cfg_port,
    input  logic [1:0]    cfg_ofs,
    input  logic          cfg_rise,
    input  logic          cfg_fall,
    output logic          hw_set
);
    logic [PW-1:0] port_q;
    logic [1:0]    ofs_q;
    logic          rise_q;
    logic          fall_q;
    logic          prev_q;
    logic          cur;
    int            idx;
    ln_state_e     state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            ofs_q  <= '0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else if (cfg_wr) begin
            port_q <= cfg_port;
            ofs_q  <= cfg_ofs;
            rise_q <= cfg_rise;
            fall_q <= cfg_fall;
        end
    end

    // pad select limited to this line's group
    always_comb begin
        idx = PINS * int'(port_q) + GBASE + int'(ofs_q);
        cur = pads_s[idx[IW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LN_SETTLE;
        end else if (cfg_wr) begin
            state <= LN_SETTLE;
        end else begin
            unique case (state)
                LN_SETTLE: state <= LN_ARMED;
                LN_ARMED:  state <= LN_ARMED;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            LN_SETTLE: hw_set = 1'b0;
            LN_ARMED:  hw_set = (rise_q &  cur & ~prev_q) |
                                (fall_q & ~cur &  prev_q);
        endcase
    end

    // R4
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !hw_set);
endmodule

// File: rtl/eir_flags.sv
module eir_flags #(
    parameter int FW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] hw_set,
    input  logic [FW-1:0] cfg_clr,
    input  logic          fset_we,
    input  logic          fclr_we,
    input  logic [FW-1:0] fdata,
    input  logic          eset_we,
    input  logic          eclr_we,
    input  logic [FW-1:0] edata,
    output logic [FW-1:0] flags,
    output logic [FW-1:0] enables
);
    logic [FW-1:0] sw_fset, sw_fclr, sw_eset, sw_eclr;

    always_comb begin
        sw_fset = fset_we ? fdata : '0;
        sw_fclr = fclr_we ? fdata : '0;
        sw_eset = eset_we ? edata : '0;
        sw_eclr = eclr_we ? edata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags   <= ((flags & ~sw_fclr) | sw_fset | hw_set) & ~cfg_clr;
            enables <= (enables & ~sw_eclr) | sw_eset;
        end
    end

    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & ~cfg_clr) != '0) |=>
        ((flags & $past(hw_set & ~cfg_clr)) == $past(hw_set & ~cfg_clr)));

    // R4
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clr != '0) |=> ((flags & $past(cfg_clr)) == '0));

    // R5
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr_we && !fset_we) |=> ((flags & $past(fdata & ~hw_set)) == '0));

    // R6
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eset_we |=> ((enables & $past(edata)) == $past(edata)));

    // R6
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eclr_we && !eset_we) |=> ((enables & $past(edata)) == '0));
endmodule

// File: rtl/eir_router.sv
module eir_router
    import eir_pkg::*;
#(
    parameter int PORTS = 4,
    parameter int PINS  = 16,
    parameter int LINES = 16,
    parameter int WAKES = 4,
    localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int LW = $clog2(LINES),
    localparam int NP = PORTS * PINS,
    localparam int FW = LINES + WAKES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    pad_in,
    input  logic [WAKES-1:0] wake_pad,
    input  logic             cfg_we,
    input  logic [LW-1:0]    cfg_line,
    input  logic [PW-1:0]    cfg_port,
    input  logic [1:0]       cfg_ofs,
    input  logic             cfg_rise,
    input  logic             cfg_fall,
    input  logic             wake_cfg_we,
    input  logic [WAKES-1:0] wake_en_wdata,
    input  logic [WAKES-1:0] wake_pol_wdata,
    input  logic             flag_set_we,
    input  logic             flag_clr_we,
    input  logic [FW-1:0]    flag_wdata,
    input  logic             en_set_we,
    input  logic             en_clr_we,
    input  logic [FW-1:0]    en_wdata,
    output logic [FW-1:0]    flags,
    output logic [FW-1:0]    enables,
    output logic [FW-1:0]    active,
    output logic             irq_any,
    output logic             irq_even,
    output logic             irq_odd,
    output logic [WAKES-1:0] wake_cause
);
    logic [NP-1:0]    pads_s;
    logic [WAKES-1:0] wake_s;
    logic [WAKES-1:0] wake_en_q, wake_pol_q;
    logic [FW-1:0]    hw_set;
    logic [FW-1:0]    cfg_clr;

    eir_sync #(.W(NP)) u_pad_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pads_s)
    );

    eir_sync #(.W(WAKES)) u_wake_sync (
        .clk(clk), .rst_n(rst_n), .d(wake_pad), .q(wake_s)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic line_wr;
        assign line_wr    = cfg_we && (cfg_line == LW'(g));
        assign cfg_clr[g] = line_wr;

        eir_line #(.LINE(g), .PORTS(PORTS), .PINS(PINS)) u_line (
            .clk(clk), .rst_n(rst_n), .pads_s(pads_s),
            .cfg_wr(line_wr), .cfg_port(cfg_port), .cfg_ofs(cfg_ofs),
            .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
            .hw_set(hw_set[g])
        );
    end

    assign cfg_clr[FW-1:LINES] = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_en_q  <= '0;
            wake_pol_q <= '0;
        end else if (wake_cfg_we) begin
            wake_en_q  <= wake_en_wdata;
            wake_pol_q <= wake_pol_wdata;
        end
    end

    // level match: active when synchronised pad equals polarity
    assign hw_set[FW-1:LINES] = wake_en_q & ~(wake_s ^ wake_pol_q);

    eir_flags #(.FW(FW)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .cfg_clr(cfg_clr),
        .fset_we(flag_set_we), .fclr_we(flag_clr_we), .fdata(flag_wdata),
        .eset_we(en_set_we), .eclr_we(en_clr_we), .edata(en_wdata),
        .flags(flags), .enables(enables)
    );

    always_comb begin
        active   = flags & enables;
        irq_any  = |active;
        irq_even = 1'b0;
        irq_odd  = 1'b0;
        for (int i = 0; i < FW; i++) begin
            if (i % 2 == 0) irq_even = irq_even | active[i];
            else            irq_odd  = irq_odd  | active[i];
        end
        wake_cause = flags[FW-1:LINES] & wake_en_q;
    end

    // R10
    wake_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en_q[0] && (wake_s[0] == wake_pol_q[0])) |=> flags[LINES]);
endmodule

// File: tb/eir_router_tb.sv
`timescale 1ns/1ps
module eir_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pad_in = '0;
    logic [3:0]  wake_pad = '0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_line = '0;
    logic [1:0]  cfg_port = '0;
    logic [1:0]  cfg_ofs = '0;
    logic        cfg_rise = 0, cfg_fall = 0;
    logic        wake_cfg_we = 0;
    logic [3:0]  wake_en_wdata = '0, wake_pol_wdata = '0;
    logic        flag_set_we = 0, flag_clr_we = 0;
    logic [19:0] flag_wdata = '0;
    logic        en_set_we = 0, en_clr_we = 0;
    logic [19:0] en_wdata = '0;
    logic [19:0] flags, enables, active;
    logic        irq_any, irq_even, irq_odd;
    logic [3:0]  wake_cause;

    int checks = 0, errors = 0;
    bit done = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    eir_router u_dut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .wake_pad(wake_pad),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_port(cfg_port), .cfg_ofs(cfg_ofs),
        .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
        .wake_cfg_we(wake_cfg_we), .wake_en_wdata(wake_en_wdata), .wake_pol_wdata(wake_pol_wdata),
        .flag_set_we(flag_set_we), .flag_clr_we(flag_clr_we), .flag_wdata(flag_wdata),
        .en_set_we(en_set_we), .en_clr_we(en_clr_we), .en_wdata(en_wdata),
        .flags(flags), .enables(enables), .active(active),
        .irq_any(irq_any), .irq_even(irq_even), .irq_odd(irq_odd), .wake_cause(wake_cause)
    );

    // ---------------- behavioural reference model ----------------
    int          m_port[16], m_ofs[16];
    bit          m_rise[16], m_fall[16], m_settle[16], m_prev[16];
    logic [63:0] m_s1, m_s2;
    logic [3:0]  m_w1, m_w2, m_wen, m_wpol;
    logic [19:0] m_fl, m_en;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 16; l++) begin
                m_port[l] = 0; m_ofs[l] = 0; m_rise[l] = 0; m_fall[l] = 0;
                m_settle[l] = 1; m_prev[l] = 0;
            end
            m_s1 = '0; m_s2 = '0; m_w1 = '0; m_w2 = '0;
            m_wen = '0; m_wpol = '0; m_fl = '0; m_en = '0;
        end else begin
            logic [19:0] hs;
            logic [19:0] fn;
            bit          nprev[16];
            hs = '0;
            for (int l = 0; l < 16; l++) begin
                bit c;
                c = m_s2[m_port[l]*16 + (l/4)*4 + m_ofs[l]];
                if (!m_settle[l] && ((m_rise[l] && c && !m_prev[l]) ||
                                     (m_fall[l] && !c && m_prev[l])))
                    hs[l] = 1'b1;
                nprev[l] = c;
            end
            for (int k = 0; k < 4; k++)
                if (m_wen[k] && (m_w2[k] == m_wpol[k])) hs[16+k] = 1'b1;
            fn = m_fl;
            if (flag_clr_we) fn = fn & ~flag_wdata;
            if (flag_set_we) fn = fn | flag_wdata;
            fn = fn | hs;
            if (cfg_we) fn[cfg_line] = 1'b0;
            m_fl = fn;
            if (en_clr_we) m_en = m_en & ~en_wdata;
            if (en_set_we) m_en = m_en | en_wdata;
            for (int l = 0; l < 16; l++) begin
                m_prev[l] = nprev[l];
                m_settle[l] = 0;
            end
            if (cfg_we) begin
                m_port[cfg_line] = cfg_port; m_ofs[cfg_line] = cfg_ofs;
                m_rise[cfg_line] = cfg_rise; m_fall[cfg_line] = cfg_fall;
                m_settle[cfg_line] = 1;
            end
            if (wake_cfg_we) begin
                m_wen = wake_en_wdata; m_wpol = wake_pol_wdata;
            end
            m_s2 = m_s1; m_s1 = pad_in;
            m_w2 = m_w1; m_w1 = wake_pad;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [19:0] ea;
            bit ev, od;
            ea = m_fl & m_en;
            ev = 0; od = 0;
            for (int i = 0; i < 20; i++) begin
                if (i % 2 == 0) ev = ev | ea[i];
                else            od = od | ea[i];
            end
            chk({phase, " flags"}, 32'(flags), 32'(m_fl));
            chk("R6 enables", 32'(enables), 32'(m_en));
            chk("R8 active", 32'(active), 32'(ea));
            chk("R8 irq_any", 32'(irq_any), 32'(ea != 0));
            chk("R9 irq_even", 32'(irq_even), 32'(ev));
            chk("R9 irq_odd", 32'(irq_odd), 32'(od));
            chk("R11 wake_cause", 32'(wake_cause), 32'(m_fl[19:16] & m_wen));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        cfg_we = 0; wake_cfg_we = 0;
        flag_set_we = 0; flag_clr_we = 0; en_set_we = 0; en_clr_we = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) tick();
    endtask

    task automatic wr_cfg(input int l, input int p, input int o, input bit r, input bit f);
        tick();
        cfg_we = 1; cfg_line = 4'(l); cfg_port = 2'(p); cfg_ofs = 2'(o);
        cfg_rise = r; cfg_fall = f;
        tick();
    endtask

    task automatic fset(input logic [19:0] d);
        tick(); flag_set_we = 1; flag_wdata = d; tick();
    endtask

    task automatic fclr(input logic [19:0] d);
        tick(); flag_clr_we = 1; flag_wdata = d; tick();
    endtask

    task automatic eset(input logic [19:0] d);
        tick(); en_set_we = 1; en_wdata = d; tick();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", 32'(flags), 0);
        chk("R1 enables", 32'(enables), 0);
        chk("R1 irq_any", 32'(irq_any), 0);

        // R2 / R3: line 5 watches port 2 pin 7 (pad bit 39)
        phase = "R3";
        wr_cfg(5, 2, 3, 1, 0);
        eset(20'h00020);
        tick(); pad_in[39] = 1;
        wait_n(4);
        chk("R3 rising sets flag5", 32'(flags[5]), 1);
        chk("R8 irq_any", 32'(irq_any), 1);
        chk("R9 odd line", 32'(irq_odd), 1);
        chk("R9 even quiet", 32'(irq_even), 0);
        phase = "R5";
        fclr(20'h00020);
        chk("R5 clear alias", 32'(flags[5]), 0);
        phase = "R2";
        tick(); pad_in[7] = 1;        // same pin, wrong port
        wait_n(5);
        tick(); pad_in[37] = 1;       // same port, other pin in group
        wait_n(5);
        chk("R2 foreign pads ignored", 32'(flags[5]), 0);
        phase = "R3";
        tick(); pad_in[39] = 0;       // falling with fall disabled
        wait_n(5);
        chk("R3 falling ignored", 32'(flags[5]), 0);
        wr_cfg(5, 2, 3, 0, 1);
        tick(); pad_in[39] = 1; wait_n(5);
        chk("R3 rising ignored", 32'(flags[5]), 0);
        tick(); pad_in[39] = 0; wait_n(5);
        chk("R3 falling sets", 32'(flags[5]), 1);

        // R4: reconfigure clears flag, keeps enable, masks selection jump
        phase = "R4";
        tick(); pad_in[20] = 1; wait_n(4);
        wr_cfg(5, 1, 0, 1, 1);        // selection jumps 0 -> 1
        chk("R4 flag cleared", 32'(flags[5]), 0);
        chk("R4 enable kept", 32'(enables[5]), 1);
        wait_n(4);
        chk("R4 no spurious edge", 32'(flags[5]), 0);

        // R7: hardware set on line 0 coincides with software clear
        phase = "R7";
        wr_cfg(0, 0, 0, 1, 0);
        wait_n(2);
        tick(); pad_in[0] = 1;
        tick();
        tick(); flag_clr_we = 1; flag_wdata = 20'h00001;
        tick();
        chk("R7 set beats clear", 32'(flags[0]), 1);

        // R5 set alias, R6 simultaneous enable set/clear
        phase = "R5";
        fset(20'h0A000);
        chk("R5 set alias", 32'(flags[15:12]), 4'hA);
        tick(); en_set_we = 1; en_clr_we = 1; en_wdata = 20'h00008; tick();
        chk("R6 set wins", 32'(enables[3]), 1);

        // R10 / R11 wake-up lines
        phase = "R10";
        tick(); wake_cfg_we = 1; wake_en_wdata = 4'b0011; wake_pol_wdata = 4'b0001; tick();
        wait_n(4);
        chk("R10 active-low line1 fires", 32'(flags[17]), 1);
        chk("R10 line0 idle", 32'(flags[16]), 0);
        chk("R10 disabled line2", 32'(flags[18]), 0);
        chk("R11 cause", 32'(wake_cause), 4'b0010);
        fclr(20'h20000);
        chk("R10 level re-sets", 32'(flags[17]), 1);
        tick(); wake_pad = 4'b0011; wait_n(4);
        fclr(20'h30000);
        chk("R10 line0 high", 32'(flags[16]), 1);
        chk("R10 line1 released", 32'(flags[17]), 0);

        // randomised mix, compared each cycle against the model
        phase = "R3";
        for (int n = 0; n < 4000; n++) begin
            tick();
            if ($urandom_range(3) == 0) pad_in[$urandom_range(63)] ^= 1'b1;
            if ($urandom_range(7) == 0) wake_pad[$urandom_range(3)] ^= 1'b1;
            if ($urandom_range(15) == 0) begin
                cfg_we = 1; cfg_line = 4'($urandom_range(15));
                cfg_port = 2'($urandom_range(3)); cfg_ofs = 2'($urandom_range(3));
                cfg_rise = 1'($urandom_range(1)); cfg_fall = 1'($urandom_range(1));
            end
            if ($urandom_range(7) == 0) begin
                flag_wdata = 20'($urandom);
                flag_set_we = 1'($urandom_range(1));
                flag_clr_we = 1'($urandom_range(1));
            end
            if ($urandom_range(7) == 0) begin
                en_wdata = 20'($urandom);
                en_set_we = 1'($urandom_range(1));
                en_clr_we = 1'($urandom_range(1));
            end
            if ($urandom_range(63) == 0) begin
                wake_cfg_we = 1;
                wake_en_wdata = 4'($urandom); wake_pol_wdata = 4'($urandom);
            end
        end
        tick();
        tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule